// File: doc/BRIEF.md
# Dual-Ring Read Return Collector

This block gathers read-return packets arriving on two 65-bit rings, a local ring and a fast ring, and hands each completed result to one consumer port. A packet takes two consecutive beats on its ring: first a control beat carrying the thread ID, ack, read/write flag and a 2-bit exception status, then a data beat carrying the 64-bit word. Each ring has its own lane. The lane registers every incoming beat, remembers the control fields of a valid control beat, and captures the data beat that directly follows it into a per-ring result register.

The consumer port accepts one result per cycle. A ring produces a result at most every other cycle, so one shared output can serve both rings. When both rings complete in the same cycle, the fast ring is delivered first. The local result waits one cycle in its result register and goes out before that register can be reloaded. All incoming beats are sampled only while the clock enable is high.

Top module: `ring_return_ctrl`

## Requirements
- R1: A control beat has bit 64 = 1 and its valid flag in bit 63. The delivered result takes the thread ID from control bits 58:56, ack from bit 62, read/write from bit 59 and the exception status from bits 49:48.
- R2: A valid control beat followed on the next sampled cycle by a data beat (bit 64 = 0) yields a one-cycle `res_vld_o` pulse. With the enable held high, the pulse comes after the third rising edge following the edge that sampled the control beat. `res_data_o` carries bits 63:0 of the data beat. If a valid control beat is followed by another valid control beat, the later one is the one paired with the next data beat.
- R3: A control beat whose valid bit is clear produces no result, even when a data beat follows it.
- R4: A data beat that is not directly preceded by a valid control beat produces no result.
- R5: While `clk_en_i` is low, ring beats are not sampled and a packet in progress is frozen. A beat presented only while the enable is low has no effect. A packet whose beats straddle an enable-low gap still completes, three cycles after its data beat is sampled.
- R6: When both rings complete a packet in the same cycle, the fast result is delivered first and the local result in the next cycle. Neither result is lost.
- R7: `res_src_o` is 1 for a result from the fast ring and 0 for one from the local ring.
- R8: During and right after reset, `res_vld_o` is low.
- R9: Back-to-back packets on both rings, a new packet every two cycles on each ring, are all delivered in order, with none lost or overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 1 | Beat sampling enable |
| fast_beat_i | input | 65 | Fast ring beat |
| local_beat_i | input | 65 | Local ring beat |
| res_vld_o | output | 1 | One-cycle result strobe |
| res_data_o | output | 64 | Returned data word |
| res_tid_o | output | 3 | Returned thread ID |
| res_ack_o | output | 1 | Returned ack bit |
| res_rw_o | output | 1 | Returned read/write bit |
| res_exc_o | output | 2 | Returned exception status |
| res_src_o | output | 1 | 1 = fast ring, 0 = local ring |

## Verification
The bench builds the block with the package defaults: a 64-bit data word, a 3-bit thread ID and a 2-bit status. Full 64-bit random data therefore exposes any swapped, dropped or shifted data bits. Random two-beat packets, holes and stray data beats run independently on both rings, so same-cycle completions (and the one-cycle hold on the local result) occur often. Directed cases cover the enable stall, a beat that is ignored while the enable is low, a control beat followed by a second control beat, and back-to-back traffic on both rings.

// File: rtl/rr_pkg.sv
package rr_pkg;
  localparam int DATA_W  = 64;
  localparam int BEAT_W  = DATA_W + 1;
  localparam int TID_W   = 3;
  localparam int EXC_W   = 2;
  localparam int N_RING  = 2;
  localparam int LOC_IDX = 0;
  localparam int FST_IDX = 1;

  // field positions inside a ring beat
  localparam int KIND_POS = DATA_W;
  localparam int VLD_POS  = DATA_W - 1;
  localparam int ACK_POS  = DATA_W - 2;
  localparam int RW_POS   = DATA_W - 5;
  localparam int TID_LSB  = DATA_W - 8;
  localparam int EXC_LSB  = DATA_W - 16;

  typedef struct packed {
    logic [TID_W-1:0] tid;
    logic             ack;
    logic             rw;
    logic [EXC_W-1:0] exc;
  } rr_ctl_t;

  typedef enum logic {SRC_LOCAL = 1'b0, SRC_FAST = 1'b1} rr_src_e;

  function automatic rr_ctl_t rr_decode(input logic [BEAT_W-1:0] b);
    rr_ctl_t c;
    c.tid = b[TID_LSB +: TID_W];
    c.ack = b[ACK_POS];
    c.rw  = b[RW_POS];
    c.exc = b[EXC_LSB +: EXC_W];
    return c;
  endfunction
endpackage

// File: rtl/rr_ring_lane.sv
module rr_ring_lane
  import rr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_en_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  logic              take_i,
  output logic              rdy_o,
  output logic [DATA_W-1:0] data_o,
  output rr_ctl_t           ctl_o
);
  logic [BEAT_W-1:0] s1_q;
  logic              pend_q;
  rr_ctl_t           ctl_hold_q;
  rr_ctl_t           ctl_q;
  logic [DATA_W-1:0] data_q;
  logic              rdy_q;
  logic              s1_is_ctl;
  logic              s1_is_data;
  logic              load;

  assign s1_is_ctl  = s1_q[KIND_POS] & s1_q[VLD_POS];
  assign s1_is_data = ~s1_q[KIND_POS];
  assign load       = clk_en_i & pend_q & s1_is_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q       <= '0;
      pend_q     <= 1'b0;
      ctl_hold_q <= '0;
    end else if (clk_en_i) begin
      s1_q   <= beat_i;
      pend_q <= s1_is_ctl;
      if (s1_is_ctl) ctl_hold_q <= rr_decode(s1_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      ctl_q  <= '0;
      rdy_q  <= 1'b0;
    end else begin
      if (load) begin
        data_q <= s1_q[DATA_W-1:0];
        ctl_q  <= ctl_hold_q;
      end
      rdy_q <= load | (rdy_q & ~take_i);
    end
  end

  assign rdy_o  = rdy_q;
  assign data_o = data_q;
  assign ctl_o  = ctl_q;

  // R9
  no_overrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_q && !take_i) |-> !load);

  // R5
  freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_i |=> ($stable(pend_q) && !$rose(rdy_q)));
endmodule

// File: rtl/rr_out_arb.sv
module rr_out_arb
  import rr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rdy_fast_i,
  input  logic [DATA_W-1:0] data_fast_i,
  input  rr_ctl_t           ctl_fast_i,
  input  logic              rdy_local_i,
  input  logic [DATA_W-1:0] data_local_i,
  input  rr_ctl_t           ctl_local_i,
  output logic              take_fast_o,
  output logic              take_local_o,
  output logic              vld_o,
  output logic [DATA_W-1:0] data_o,
  output rr_ctl_t           ctl_o,
  output rr_src_e           src_o
);
  // fast ring wins; local waits at most one cycle
  assign take_fast_o  = rdy_fast_i;
  assign take_local_o = rdy_local_i & ~rdy_fast_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      data_o <= '0;
      ctl_o  <= '0;
      src_o  <= SRC_LOCAL;
    end else begin
      vld_o <= take_fast_o | take_local_o;
      if (take_fast_o) begin
        data_o <= data_fast_i;
        ctl_o  <= ctl_fast_i;
        src_o  <= SRC_FAST;
      end else if (take_local_o) begin
        data_o <= data_local_i;
        ctl_o  <= ctl_local_i;
        src_o  <= SRC_LOCAL;
      end
    end
  end

  // R6
  local_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_fast_i && rdy_local_i) |=> (rdy_local_i && !rdy_fast_i));

  // R7
  src_fast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && src_o == SRC_FAST) |-> $past(rdy_fast_i));

  // R2
  deliver_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_fast_i || rdy_local_i) |=> vld_o);
endmodule

// File: rtl/ring_return_ctrl.sv
module ring_return_ctrl
  import rr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_en_i,
  input  logic [BEAT_W-1:0] fast_beat_i,
  input  logic [BEAT_W-1:0] local_beat_i,
  output logic              res_vld_o,
  output logic [DATA_W-1:0] res_data_o,
  output logic [TID_W-1:0]  res_tid_o,
  output logic              res_ack_o,
  output logic              res_rw_o,
  output logic [EXC_W-1:0]  res_exc_o,
  output logic              res_src_o
);
  logic [BEAT_W-1:0] beat_a [N_RING];
  logic              rdy_a  [N_RING];
  logic              take_a [N_RING];
  logic [DATA_W-1:0] data_a [N_RING];
  rr_ctl_t           ctl_a  [N_RING];
  rr_ctl_t           res_ctl;
  rr_src_e           res_src;

  assign beat_a[LOC_IDX] = local_beat_i;
  assign beat_a[FST_IDX] = fast_beat_i;

  for (genvar g = 0; g < N_RING; g++) begin : g_lane
    rr_ring_lane u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clk_en_i (clk_en_i),
      .beat_i   (beat_a[g]),
      .take_i   (take_a[g]),
      .rdy_o    (rdy_a[g]),
      .data_o   (data_a[g]),
      .ctl_o    (ctl_a[g])
    );
  end

  rr_out_arb u_arb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rdy_fast_i   (rdy_a[FST_IDX]),
    .data_fast_i  (data_a[FST_IDX]),
    .ctl_fast_i   (ctl_a[FST_IDX]),
    .rdy_local_i  (rdy_a[LOC_IDX]),
    .data_local_i (data_a[LOC_IDX]),
    .ctl_local_i  (ctl_a[LOC_IDX]),
    .take_fast_o  (take_a[FST_IDX]),
    .take_local_o (take_a[LOC_IDX]),
    .vld_o        (res_vld_o),
    .data_o       (res_data_o),
    .ctl_o        (res_ctl),
    .src_o        (res_src)
  );

  assign res_tid_o = res_ctl.tid;
  assign res_ack_o = res_ctl.ack;
  assign res_rw_o  = res_ctl.rw;
  assign res_exc_o = res_ctl.exc;
  assign res_src_o = res_src;

  // R8
  reset_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !res_vld_o);
endmodule

// File: tb/ring_return_ctrl_tb_top.sv
`timescale 1ns/1ps
module ring_return_ctrl_tb_top;
  localparam int NSLOT = 2048;
  localparam int NRAND = 1500;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        clk_en_i;
  logic [64:0] fast_beat_i;
  logic [64:0] local_beat_i;
  logic        res_vld_o;
  logic [63:0] res_data_o;
  logic [2:0]  res_tid_o;
  logic        res_ack_o;
  logic        res_rw_o;
  logic [1:0]  res_exc_o;
  logic        res_src_o;

  always #4 clk_i = ~clk_i;

  ring_return_ctrl dut_i (
    .clk_i, .rst_ni, .clk_en_i, .fast_beat_i, .local_beat_i,
    .res_vld_o, .res_data_o, .res_tid_o, .res_ack_o, .res_rw_o,
    .res_exc_o, .res_src_o
  );

  int    n_chk = 0;
  int    n_err = 0;
  int    idx   = 0;
  bit    done  = 0;

  logic        exp_vld  [NSLOT];
  logic [63:0] exp_data [NSLOT];
  logic [2:0]  exp_tid  [NSLOT];
  logic        exp_ack  [NSLOT];
  logic        exp_rw   [NSLOT];
  logic [1:0]  exp_exc  [NSLOT];
  logic        exp_src  [NSLOT];
  string       exp_tag  [NSLOT];

  function automatic logic [64:0] ctl_beat(logic vld, logic ack, logic rw,
                                           logic [2:0] tid, logic [1:0] exc);
    logic [5:0]  mid  = 6'($urandom);
    logic [1:0]  cls  = 2'($urandom);
    logic [47:0] addr = {16'($urandom), 32'($urandom)};
    return {1'b1, vld, ack, cls, rw, tid, mid, exc, addr};
  endfunction

  function automatic logic [64:0] rnd_ctl(logic vld);
    return ctl_beat(vld, 1'($urandom), 1'($urandom), 3'($urandom), 2'($urandom));
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  // expectation from R1/R2/R6/R7: slot = data-beat step + 3, local +1 on clash
  task automatic sched(bit fast, logic [64:0] c, logic [63:0] d, string tag);
    int s = idx + 3;
    if (!fast && exp_vld[s] && exp_src[s]) s++;
    exp_vld[s]  = 1'b1;
    exp_data[s] = d;
    exp_tid[s]  = c[58:56];
    exp_ack[s]  = c[62];
    exp_rw[s]   = c[59];
    exp_exc[s]  = c[49:48];
    exp_src[s]  = fast;
    exp_tag[s]  = (s != idx + 3) ? "R6" : tag;
  endtask

  task automatic fail_line(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_err++;
    $display("FAIL %s: %s slot %0d actual %0h expected %0h", tag, what, idx, act, exp);
  endtask

  task automatic check_slot();
    n_chk++;
    if (res_vld_o !== exp_vld[idx])
      fail_line(exp_tag[idx], "res_vld", 64'(res_vld_o), 64'(exp_vld[idx]));
    if (exp_vld[idx]) begin
      n_chk++;
      if (res_data_o !== exp_data[idx]) fail_line("R2", "data", res_data_o, exp_data[idx]);
      n_chk++;
      if ({res_tid_o, res_ack_o, res_rw_o, res_exc_o} !==
          {exp_tid[idx], exp_ack[idx], exp_rw[idx], exp_exc[idx]})
        fail_line("R1", "tid/ack/rw/exc",
                  64'({res_tid_o, res_ack_o, res_rw_o, res_exc_o}),
                  64'({exp_tid[idx], exp_ack[idx], exp_rw[idx], exp_exc[idx]}));
      n_chk++;
      if (res_src_o !== exp_src[idx]) fail_line("R7", "src", 64'(res_src_o), 64'(exp_src[idx]));
    end
  endtask

  task automatic step(logic [64:0] fb, logic [64:0] lb, logic ck);
    @(negedge clk_i);
    check_slot();
    fast_beat_i  = fb;
    local_beat_i = lb;
    clk_en_i     = ck;
    idx++;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step('0, '0, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [64:0] c, c2, fc, lc;
    logic [63:0] d, d2;
    logic        f_pend, l_pend;
    void'($urandom(32'h1d5e_a7c3));
    for (int k = 0; k < NSLOT; k++) begin
      exp_vld[k] = 1'b0; exp_data[k] = '0; exp_tid[k] = '0; exp_ack[k] = 1'b0;
      exp_rw[k] = 1'b0; exp_exc[k] = '0; exp_src[k] = 1'b0; exp_tag[k] = "R4";
    end
    rst_ni = 1'b0; clk_en_i = 1'b1; fast_beat_i = '0; local_beat_i = '0;
    repeat (3) @(negedge clk_i);
    n_chk++;
    if (res_vld_o !== 1'b0) fail_line("R8", "res_vld in reset", 64'(res_vld_o), 64'd0);
    rst_ni = 1'b1;
    exp_tag[0] = "R8";

    // R1 R2 R7: single fast packet
    c = ctl_beat(1'b1, 1'b1, 1'b0, 3'd5, 2'b10); d = rnd64();
    step(c, '0, 1'b1); sched(1, c, d, "R2"); step({1'b0, d}, '0, 1'b1); idle(5);
    // R7: single local packet
    c = ctl_beat(1'b1, 1'b0, 1'b1, 3'd2, 2'b01); d = rnd64();
    step('0, c, 1'b1); sched(0, c, d, "R7"); step('0, {1'b0, d}, 1'b1); idle(5);
    // R6: simultaneous completion
    c = rnd_ctl(1'b1); c2 = rnd_ctl(1'b1); d = rnd64(); d2 = rnd64();
    step(c, c2, 1'b1); sched(1, c, d, "R6"); sched(0, c2, d2, "R6");
    step({1'b0, d}, {1'b0, d2}, 1'b1); idle(6);
    // R3: hole control then data on both rings
    step(rnd_ctl(1'b0), rnd_ctl(1'b0), 1'b1);
    exp_tag[idx + 3] = "R3"; exp_tag[idx + 4] = "R3";
    step({1'b0, rnd64()}, {1'b0, rnd64()}, 1'b1); idle(6);
    // R4: stray data beats
    exp_tag[idx + 3] = "R4"; step({1'b0, rnd64()}, {1'b0, rnd64()}, 1'b1);
    exp_tag[idx + 3] = "R4"; step({1'b0, rnd64()}, '0, 1'b1); idle(6);
    // R2: control, control, data - later control is paired
    c = rnd_ctl(1'b1); c2 = rnd_ctl(1'b1); d = rnd64();
    step(c, '0, 1'b1); step(c2, '0, 1'b1); sched(1, c2, d, "R2");
    step({1'b0, d}, '0, 1'b1); idle(6);
    // R5: control presented only while enable low is ignored
    step(rnd_ctl(1'b1), rnd_ctl(1'b1), 1'b0);
    exp_tag[idx + 3] = "R5"; exp_tag[idx + 4] = "R5";
    step({1'b0, rnd64()}, {1'b0, rnd64()}, 1'b1); idle(6);
    // R5: enable-low gap inside a packet
    c = rnd_ctl(1'b1); d = rnd64();
    step('0, c, 1'b1);
    exp_tag[idx + 3] = "R5"; step('0, {1'b0, rnd64()}, 1'b0);
    exp_tag[idx + 3] = "R5"; step('0, {1'b0, rnd64()}, 1'b0);
    sched(0, c, d, "R5"); step('0, {1'b0, d}, 1'b1); idle(6);
    // R9: back-to-back on both rings
    for (int p = 0; p < 4; p++) begin
      c = rnd_ctl(1'b1); c2 = rnd_ctl(1'b1); d = rnd64(); d2 = rnd64();
      step(c, c2, 1'b1); sched(1, c, d, "R9"); sched(0, c2, d2, "R9");
      step({1'b0, d}, {1'b0, d2}, 1'b1);
    end
    idle(8);

    // random phase
    f_pend = 1'b0; l_pend = 1'b0; fc = '0; lc = '0;
    for (int t = 0; t < NRAND; t++) begin
      logic [64:0] fb, lb;
      int r;
      if (f_pend) begin
        d = rnd64(); fb = {1'b0, d}; sched(1, fc, d, "R2"); f_pend = 1'b0;
      end else begin
        r = int'($urandom % 10);
        if (r < 4) begin fc = rnd_ctl(1'b1); fb = fc; f_pend = 1'b1; end
        else if (r < 6) fb = rnd_ctl(1'b0);
        else if (r < 8) fb = {1'b0, rnd64()};
        else fb = '0;
      end
      if (l_pend) begin
        d = rnd64(); lb = {1'b0, d}; sched(0, lc, d, "R2"); l_pend = 1'b0;
      end else begin
        r = int'($urandom % 10);
        if (r < 4) begin lc = rnd_ctl(1'b1); lb = lc; l_pend = 1'b1; end
        else if (r < 6) lb = rnd_ctl(1'b0);
        else if (r < 8) lb = {1'b0, rnd64()};
        else lb = '0;
      end
      step(fb, lb, 1'b1);
    end
    // complete any open packet with a data beat
    if (f_pend) begin d = rnd64(); sched(1, fc, d, "R2"); end
    if (l_pend) begin d2 = rnd64(); sched(0, lc, d2, "R2"); end
    step(f_pend ? {1'b0, d} : 65'd0, l_pend ? {1'b0, d2} : 65'd0, 1'b1);
    idle(10);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule